// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a small serial memory. It oversamples the two-wire clock and data lines with the system clock, finds start and stop conditions, and takes in the first byte after a start as a slave address. The upper nibble of that byte picks a memory access or a utility command. Three strap inputs give each part its own bus identity, so up to eight parts can share one pair of wires. The data line is never driven high: the block only asserts a pull-down enable.

In a memory write, the first data byte sets an internal byte pointer. Each later byte is presented on a byte-wide write port at the pointer, and the pointer then advances. A write-protect input stops the write strobes but leaves the bus protocol unchanged. Reads take data from the memory port at the pointer, send it out MSB first, and advance the pointer per byte. A matched utility address raises a one-cycle strobe that carries the read/write bit. Decoding the utility command itself is left to logic outside this block.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start (data line falling while the clock line is high) begins address reception from any state. A stop (data line rising while the clock line is high) returns the slave to idle with `sda_oe` low, and later bytes get no acknowledge until the next start.
- R2: Before the first start, clocked bus traffic is ignored. `sda_oe` stays low and no `mem_we` or `util_stb` pulse appears. After reset `sda_oe`, `mem_we` and `util_stb` are all low.
- R3: The address byte is received MSB first. Bits 7:4 equal to 1010b select a memory access and 0110b select a utility command. Bits 3:1 must equal `strap_addr[2:0]`. Bit 0 set to 1 means read and 0 means write. On a match the slave holds `sda_oe` high through the 9th clock.
- R4: An address byte whose upper nibble is neither code, or whose bits 3:1 differ from the straps, gets no acknowledge, and the slave stays idle until the next start.
- R5: In a memory write, the first data byte loads the pointer and causes no write. Each later byte produces one `mem_we` pulse of one system-clock cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte, and the pointer then advances by one. Every data byte is acknowledged.
- R6: A byte that completes while `wr_protect` is high produces no `mem_we` pulse. It is still acknowledged, and the pointer still advances.
- R7: In a memory read, each byte is the value of `mem_rdata` at the pointer, sent MSB first: `sda_oe` high for a 0 bit and low for a 1 bit. The pointer advances once per byte. `sda_oe` changes only while the clock line is low.
- R8: During a read, a master acknowledge (line low in the 9th clock) starts the next byte. A no-acknowledge makes the slave release the line and ignore traffic until the next start.
- R9: An acknowledged utility address raises `util_stb` for one cycle, with `util_rnw` equal to address bit 0. It produces no `mem_we`, and the slave then idles until the next start.
- R10: A repeated start, even in the middle of a data byte, restarts address reception without a write strobe and keeps the pointer. A later read therefore returns data from the pointer loaded before the repeated start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| strap_addr | input | 3 | Pin-strapped slave identity, compared with address bits 3:1 |
| wr_protect | input | 1 | When high, memory write strobes are suppressed |
| mem_addr | output | ADDR_W | Byte pointer used for both reads and writes |
| mem_wdata | output | 8 | Write data, valid with `mem_we` |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Read data at `mem_addr`, combinational from the array |
| util_stb | output | 1 | One-cycle pulse on an acknowledged utility address |
| util_rnw | output | 1 | Read/write bit of the last utility address |

## Verification
The bench walks a table of address bytes that differ in one field at a time: each preamble code, a foreign nibble, and wrong straps in read and write form. A decoder that checks only part of the byte would acknowledge a foreign part or drop a utility strobe. Directed tests first clock a valid address before any start, where a slave that ignores the start requirement would acknowledge it. They then toggle write-protect between bytes of one transfer, which catches a pointer that freezes under protection. They also break a data byte with a repeated start, where a write strobe must not appear and the pointer must persist. After a master no-acknowledge they clock another byte with no start, where a slave that keeps transmitting would pull the line low. A monitor flags any `sda_oe` change while the clock line is high, since such a change would look like a start or stop on a real bus.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_t;

  localparam logic [3:0] PRE_MEM  = 4'b1010;
  localparam logic [3:0] PRE_UTIL = 4'b0110;
  localparam int unsigned BYTE_W  = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  // lines idle high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges count as conditions only while clock was high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_addr,
  input  logic              wr_protect,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  output logic              util_stb,
  output logic              util_rnw
);

  localparam int unsigned NLINES = 2;
  localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;

  // ---------------- input conditioning ----------------
  logic [NLINES-1:0] raw_lines, syn_lines;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines[g]),
      .q     (syn_lines[g])
    );
  end

  assign scl_s = syn_lines[1];
  assign sda_s = syn_lines[0];

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // ---------------- state ----------------
  slv_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [7:0]        sh_q, sh_n;
  logic              oe_q, oe_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              ptr_ok_q, ptr_ok_n;
  logic              rd_q, rd_n;
  logic              util_q, util_n;
  logic              bump_q, bump_n;
  logic              we_q, we_n;
  logic [7:0]        wdata_q, wdata_n;
  logic              ustb_q, ustb_n;
  logic              urnw_q, urnw_n;

  logic cnt_full, is_mem, is_util, addr_hit;

  assign cnt_full = cnt_q[CNT_W-1];
  assign is_mem   = (sh_q[7:4] == PRE_MEM);
  assign is_util  = (sh_q[7:4] == PRE_UTIL);
  assign addr_hit = (is_mem | is_util) & (sh_q[3:1] == strap_addr);

  // ---------------- next state ----------------
  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    oe_n     = oe_q;
    ptr_n    = ptr_q;
    ptr_ok_n = ptr_ok_q;
    rd_n     = rd_q;
    util_n   = util_q;
    bump_n   = 1'b0;
    we_n     = 1'b0;
    wdata_n  = wdata_q;
    ustb_n   = 1'b0;
    urnw_n   = urnw_q;

    // pointer advance one cycle after a completed write byte
    if (bump_q) ptr_n = ptr_q + ADDR_W'(1);

    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;

        ST_ADDR, ST_WDATA: begin
          if (scl_rise && !cnt_full) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_full) begin
            cnt_n = '0;
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                oe_n     = 1'b1;
                st_n     = ST_ACK;
                rd_n     = is_mem & sh_q[0];
                util_n   = is_util;
                ptr_ok_n = 1'b0;
                if (is_util) begin
                  ustb_n = 1'b1;
                  urnw_n = sh_q[0];
                end
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              oe_n = 1'b1;
              st_n = ST_ACK;
              if (!ptr_ok_q) begin
                ptr_n    = ADDR_W'(sh_q);
                ptr_ok_n = 1'b1;
              end else begin
                bump_n = 1'b1;
                if (!wr_protect) begin
                  we_n    = 1'b1;
                  wdata_n = sh_q;
                end
              end
            end
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            if (util_q) begin
              st_n = ST_IDLE;
            end else if (rd_q) begin
              st_n  = ST_RDATA;
              sh_n  = mem_rdata;
              oe_n  = ~mem_rdata[7];
              ptr_n = ptr_q + ADDR_W'(1);
            end else begin
              st_n = ST_WDATA;
            end
          end
        end

        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_full) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              oe_n = ~sh_q[3'd7 - cnt_q[2:0]];
            end
          end
        end

        ST_RACK: begin
          if (scl_rise) begin
            if (sda_s) st_n = ST_IDLE;   // master declined further data
          end else if (scl_fall) begin
            st_n  = ST_RDATA;
            cnt_n = '0;
            sh_n  = mem_rdata;
            oe_n  = ~mem_rdata[7];
            ptr_n = ptr_q + ADDR_W'(1);
          end
        end

        default: st_n = ST_IDLE;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
      ptr_ok_q <= 1'b0;
      rd_q     <= 1'b0;
      util_q   <= 1'b0;
      bump_q   <= 1'b0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      ustb_q   <= 1'b0;
      urnw_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      oe_q     <= oe_n;
      ptr_q    <= ptr_n;
      ptr_ok_q <= ptr_ok_n;
      rd_q     <= rd_n;
      util_q   <= util_n;
      bump_q   <= bump_n;
      we_q     <= we_n;
      wdata_q  <= wdata_n;
      ustb_q   <= ustb_n;
      urnw_q   <= urnw_n;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_addr  = ptr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign util_stb  = ustb_q;
  assign util_rnw  = urnw_q;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic sda_oe,
  input logic mem_we,
  input logic util_stb,
  input logic wr_protect
);

  // R6: no write strobe follows a byte completed under protection
  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(wr_protect));

  // R5: write strobe lasts one cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R9: utility strobe lasts one cycle and never coincides with a write
  p_util_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    util_stb |=> !util_stb);

  p_util_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    util_stb |-> !mem_we);

  // R7: the pull-down is applied only while the sampled clock line is low
  p_oe_rise_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R1: a stop leaves the line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .sda_oe     (sda_oe),
  .mem_we     (mem_we),
  .util_stb   (util_stb),
  .wr_protect (wr_protect)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;

  localparam int Q = 10;          // system clocks per quarter bus bit
  localparam logic [2:0] STRAP = 3'b101;

  // {address byte, expect ack, expect utility strobe}
  localparam int NV = 8;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {8'hAA, 1'b1, 1'b0},
    {8'hAB, 1'b1, 1'b0},
    {8'h6A, 1'b1, 1'b1},
    {8'h6B, 1'b1, 1'b1},
    {8'hA8, 1'b0, 1'b0},
    {8'hAF, 1'b0, 1'b0},
    {8'hBA, 1'b0, 1'b0},
    {8'h62, 1'b0, 1'b0}
  };

  logic clk, rst_n;
  logic scl_m, sda_m, wp;
  logic sda_oe, mem_we, util_stb, util_rnw;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_line;
  logic [7:0] mem [0:255];

  int total, bad, we_cnt, util_cnt, oe_hi_chg;
  logic [7:0] last_waddr;
  logic last_urnw, prev_oe, done;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  i2c_mem_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .strap_addr (STRAP),
    .wr_protect (wp),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rdata  (mem_rdata),
    .util_stb   (util_stb),
    .util_rnw   (util_rnw)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h30] = 8'hC3;
  end

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt        <= we_cnt + 1;
      last_waddr    <= mem_addr;
    end
    if (util_stb) begin
      util_cnt  <= util_cnt + 1;
      last_urnw <= util_rnw;
    end
    prev_oe <= sda_oe;
    if (rst_n && scl_m && (sda_oe !== prev_oe)) oe_hi_chg <= oe_hi_chg + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    scl_m = 1'b0; qw();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    b = sda_line; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(x);
    ack = ~x;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic m_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      read_bit(x);
      d[i] = x;
    end
    send_bit(~m_ack);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int w0, u0;
    total = 0; bad = 0; we_cnt = 0; util_cnt = 0; oe_hi_chg = 0;
    last_waddr = '0; last_urnw = 1'b0; prev_oe = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state (R2)
    chk("R2 reset sda_oe", sda_oe, 0);
    chk("R2 reset mem_we", mem_we, 0);
    chk("R2 reset util_stb", util_stb, 0);

    // traffic before any start (R2)
    scl_m = 1'b0; qw();
    write_byte(8'hAA, ack);
    chk("R2 no ack before start", ack, 0);
    write_byte(8'h6A, ack);
    chk("R2 no utility ack before start", ack, 0);
    chk("R2 no utility strobe before start", util_cnt, 0);
    bus_stop();

    // table of address bytes (R3, R4, R9)
    for (int i = 0; i < NV; i++) begin
      u0 = util_cnt; w0 = we_cnt;
      bus_start();
      write_byte(VEC[i][9:2], ack);
      chk($sformatf("R3/R4 addr %02h ack", VEC[i][9:2]), ack, VEC[i][1]);
      if (ack && !VEC[i][0] && VEC[i][2]) read_byte(d, 1'b0);
      repeat (4) @(negedge clk);
      chk($sformatf("R9 addr %02h util pulses", VEC[i][9:2]), util_cnt - u0, VEC[i][0]);
      if (VEC[i][0]) chk("R9 util_rnw", last_urnw, VEC[i][2]);
      chk("R9 no write on address", we_cnt - w0, 0);
      bus_stop();
    end

    // sequential write (R5)
    w0 = we_cnt;
    bus_start();
    write_byte(8'hAA, ack); chk("R5 addr ack", ack, 1);
    write_byte(8'h10, ack); chk("R5 pointer byte ack", ack, 1);
    chk("R5 pointer byte writes nothing", we_cnt - w0, 0);
    write_byte(8'h11, ack); chk("R5 data ack 1", ack, 1);
    write_byte(8'h22, ack); chk("R5 data ack 2", ack, 1);
    write_byte(8'h33, ack); chk("R5 data ack 3", ack, 1);
    bus_stop();
    chk("R5 write count", we_cnt - w0, 3);
    chk("R5 mem 10", mem[8'h10], 8'h11);
    chk("R5 mem 11", mem[8'h11], 8'h22);
    chk("R5 mem 12", mem[8'h12], 8'h33);
    chk("R5 last write address", last_waddr, 8'h12);

    // random read with repeated start (R7, R8, R10)
    bus_start();
    write_byte(8'hAA, ack);
    write_byte(8'h10, ack);
    bus_start();
    write_byte(8'hAB, ack); chk("R10 read addr ack after repeated start", ack, 1);
    read_byte(d, 1'b1); chk("R7 read byte 0", d, 8'h11);
    read_byte(d, 1'b1); chk("R8 read byte 1 after master ack", d, 8'h22);
    read_byte(d, 1'b0); chk("R7 read byte 2", d, 8'h33);
    read_byte(d, 1'b0); chk("R8 released after no-ack", d, 8'hFF);
    chk("R8 sda_oe low after no-ack", sda_oe, 0);
    bus_stop();

    // write protect toggled inside one transfer (R6)
    w0 = we_cnt;
    wp = 1'b1;
    bus_start();
    write_byte(8'hAA, ack);
    write_byte(8'h20, ack);
    write_byte(8'h55, ack); chk("R6 protected byte acked", ack, 1);
    write_byte(8'h66, ack); chk("R6 protected byte acked 2", ack, 1);
    chk("R6 no strobe while protected", we_cnt - w0, 0);
    wp = 1'b0;
    write_byte(8'h77, ack);
    bus_stop();
    chk("R6 single strobe after release", we_cnt - w0, 1);
    chk("R6 pointer advanced under protect", last_waddr, 8'h22);
    chk("R6 mem 20 untouched", mem[8'h20], 8'h00);
    chk("R6 mem 22 written", mem[8'h22], 8'h77);

    // repeated start in the middle of a data byte (R10)
    w0 = we_cnt;
    bus_start();
    write_byte(8'hAA, ack);
    write_byte(8'h30, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    write_byte(8'hAB, ack); chk("R10 ack after mid-byte start", ack, 1);
    read_byte(d, 1'b0);
    chk("R10 read at kept pointer", d, 8'hC3);
    chk("R10 no write from broken byte", we_cnt - w0, 0);
    bus_stop();

    // stop ends the transfer (R1)
    w0 = we_cnt;
    bus_start();
    write_byte(8'hAA, ack);
    write_byte(8'h40, ack);
    bus_stop();
    chk("R1 sda_oe low after stop", sda_oe, 0);
    scl_m = 1'b0; qw();
    write_byte(8'h99, ack);
    chk("R1 no ack after stop", ack, 0);
    write_byte(8'h98, ack);
    bus_stop();
    chk("R1 no write after stop", we_cnt - w0, 0);

    chk("R7 sda_oe changes while clock high", oe_hi_chg, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule